// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Field-Selectable Alarm

This block keeps time of day from a one-pulse-per-second strobe. Seconds and minutes run 00 to 59 and hours 00 to 23, all held as two-digit BCD. A 15-bit binary day number sits above the hours. Software loads the time, the alarm values and the controls through a byte-wide register port, and reads them back through the same port. The port has an address, write data, a write strobe and combinational read data.

At each tick where the seconds roll over to 00, an alarm comparator checks the newly reached minute, hour and day against the stored alarm values. Only the fields that are individually enabled take part. A full match sets a sticky flag. That flag, gated by an interrupt enable, drives the interrupt pin. A busy bit reports the cycle in which a tick is being applied. Register writes that land in that cycle are dropped, so a software load can never collide with a carry.

The register port is a plain control interface with no flow control. Writes complete in one cycle unless they collide with a tick, and reads are combinational.

Top module: `rtc_bcd_cal`

## Requirements
- R1: After reset every readable register (addresses 0x14 through 0x1D) reads 0x00 and `alarm_irq` is low.
- R2: While running, each `sec_tick` advances the seconds register (0x15) by one in BCD: a low digit of 9 becomes 0 with a tens carry, and 0x59 becomes 0x00 with a carry into minutes.
- R3: Minutes (0x16) count BCD 0x00 to 0x59 and wrap to 0x00 with a carry into hours. Hours (0x17) count BCD 0x00 to 0x23 and wrap to 0x00 with a carry into the day count. A carry moves through all fields in the cycle of the tick.
- R4: The day count is a 15-bit binary number. Address 0x18 holds bits 7:0 and address 0x19 holds bits 14:8 in its bits 6:0, with bit 7 reading 0. The count increments by one on an hour wrap and goes from 0x7FFF to 0.
- R5: Control bit 0 (address 0x14) is the run enable. While it is 0, ticks change no time register.
- R6: A write to 0x15–0x19 loads that time field, and a write to 0x1A (alarm minute), 0x1B (alarm hour), 0x1C (alarm day bits 7:0) or 0x1D (alarm day bits 14:8) loads that alarm field. All of these read back as written, masked to the field width. Unmapped addresses read 0x00.
- R7: Control bits 3, 4 and 5 enable the minute, hour and day alarm fields. At a tick where the seconds roll to 00, the flag (control bit 2) sets if at least one field is enabled and every enabled field equals the newly reached value. At no other time does the flag set, and with no field enabled it never sets.
- R8: Writing control with bit 2 = 1 clears the flag. Writing it with bit 2 = 0 leaves the flag unchanged.
- R9: `alarm_irq` is high exactly when the flag and control bit 1 (interrupt enable) are both 1.
- R10: Control bit 7 reads 1 only in a cycle where `sec_tick` is high and run is enabled. Bit 7 is not writable, and any register write in such a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The hardest condition to reach from the ports is a day-field alarm. It needs a single tick to ripple from 59 seconds through 59 minutes and 23 hours into the day count, and the comparison must use the day value being entered. The stimulus reaches it by loading the time to one second before midnight, with only the day alarm enabled, before ticking. A second hard case is a write that lands in the same cycle as a tick. The bench drives the write strobe and `sec_tick` on the same clock edge and then checks that the tick won.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam logic [7:0] A_CTRL  = 8'h14;
  localparam logic [7:0] A_SEC   = 8'h15;
  localparam logic [7:0] A_MIN   = 8'h16;
  localparam logic [7:0] A_HOUR  = 8'h17;
  localparam logic [7:0] A_DAYL  = 8'h18;
  localparam logic [7:0] A_DAYH  = 8'h19;
  localparam logic [7:0] A_AMIN  = 8'h1A;
  localparam logic [7:0] A_AHOUR = 8'h1B;
  localparam logic [7:0] A_ADAYL = 8'h1C;
  localparam logic [7:0] A_ADAYH = 8'h1D;

  localparam int B_BUSY = 7;
  localparam int B_DAE  = 5;
  localparam int B_HAE  = 4;
  localparam int B_MAE  = 3;
  localparam int B_FLAG = 2;
  localparam int B_AIE  = 1;
  localparam int B_RUN  = 0;

  typedef struct packed {
    logic day_en;
    logic hour_en;
    logic min_en;
    logic aie;
    logic run;
  } ctl_t;
endpackage

// File: rtl/rtcc_bcd_field.sv
// Two-digit BCD counter with a wrap value and a parallel load.
module rtcc_bcd_field #(
  parameter int         W   = 7,
  parameter logic [7:0] TOP = 8'h59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt,
  output logic         wrap
);
  localparam logic [W-1:0] TOPV = TOP[W-1:0];

  always_comb begin
    wrap = (q == TOPV);
    if (wrap)
      q_nxt = '0;
    else if (q[3:0] == 4'd9)
      q_nxt = {q[W-1:4] + 1'b1, 4'd0};
    else
      q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q_nxt;
  end
endmodule

// File: rtl/rtcc_day_count.sv
// Binary day counter loaded one byte at a time; wraps at all-ones.
module rtcc_day_count #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [7:0]       wdata,
  output logic [DAY_W-1:0] q,
  output logic [DAY_W-1:0] q_nxt
);
  localparam int HI_W = DAY_W - 8;

  assign q_nxt = q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (ld_lo) q[7:0] <= wdata;
    else if (ld_hi) q[DAY_W-1:8] <= wdata[HI_W-1:0];
    else if (inc) q <= q_nxt;
  end
endmodule

// File: rtl/rtcc_alarm_cmp.sv
// Match of the enabled alarm fields against the time being entered.
module rtcc_alarm_cmp #(
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 15
) (
  input  logic              en_min,
  input  logic              en_hour,
  input  logic              en_day,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [DAY_W-1:0]  alm_day,
  output logic              hit
);
  logic any_en, ok_min, ok_hour, ok_day;

  always_comb begin
    any_en  = en_min | en_hour | en_day;
    ok_min  = !en_min  || (cur_min  == alm_min);
    ok_hour = !en_hour || (cur_hour == alm_hour);
    ok_day  = !en_day  || (cur_day  == alm_day);
    hit     = any_en && ok_min && ok_hour && ok_day;
  end
endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal #(
  parameter int SEC_W  = 7,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       alarm_irq
);
  import rtcc_pkg::*;

  localparam int HI_W = DAY_W - 8;

  ctl_t              ctl;
  logic              flag;
  logic              run_en;
  logic              busy;
  logic              wr_ok;
  logic              sec_inc, min_inc, hour_inc, day_inc;
  logic              sec_wrap, min_wrap, hour_wrap;
  logic [SEC_W-1:0]  sec_q, sec_nxt;
  logic [MIN_W-1:0]  min_q, min_nxt;
  logic [HOUR_W-1:0] hour_q, hour_nxt, hour_new;
  logic [DAY_W-1:0]  day_q, day_nxt, day_new;
  logic [MIN_W-1:0]  alm_min;
  logic [HOUR_W-1:0] alm_hour;
  logic [DAY_W-1:0]  alm_day;
  logic              hit;
  logic              roll;

  assign run_en   = ctl.run;
  assign busy     = sec_tick & run_en;
  assign wr_ok    = reg_we & ~busy;
  assign sec_inc  = busy;
  assign min_inc  = sec_inc & sec_wrap;
  assign hour_inc = min_inc & min_wrap;
  assign day_inc  = hour_inc & hour_wrap;
  assign roll     = min_inc;

  rtcc_bcd_field #(.W(SEC_W), .TOP(8'h59)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_inc),
    .ld(wr_ok && reg_addr == A_SEC), .ld_val(reg_wdata[SEC_W-1:0]),
    .q(sec_q), .q_nxt(sec_nxt), .wrap(sec_wrap)
  );

  rtcc_bcd_field #(.W(MIN_W), .TOP(8'h59)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(min_inc),
    .ld(wr_ok && reg_addr == A_MIN), .ld_val(reg_wdata[MIN_W-1:0]),
    .q(min_q), .q_nxt(min_nxt), .wrap(min_wrap)
  );

  rtcc_bcd_field #(.W(HOUR_W), .TOP(8'h23)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(hour_inc),
    .ld(wr_ok && reg_addr == A_HOUR), .ld_val(reg_wdata[HOUR_W-1:0]),
    .q(hour_q), .q_nxt(hour_nxt), .wrap(hour_wrap)
  );

  rtcc_day_count #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(day_inc),
    .ld_lo(wr_ok && reg_addr == A_DAYL),
    .ld_hi(wr_ok && reg_addr == A_DAYH),
    .wdata(reg_wdata), .q(day_q), .q_nxt(day_nxt)
  );

  // Values the time takes after this tick, for the alarm compare.
  assign hour_new = hour_inc ? hour_nxt : hour_q;
  assign day_new  = day_inc  ? day_nxt  : day_q;

  rtcc_alarm_cmp #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)) u_cmp (
    .en_min(ctl.min_en), .en_hour(ctl.hour_en), .en_day(ctl.day_en),
    .cur_min(min_nxt), .cur_hour(hour_new), .cur_day(day_new),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
    .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_ok && reg_addr == A_CTRL) begin
      ctl.day_en  <= reg_wdata[B_DAE];
      ctl.hour_en <= reg_wdata[B_HAE];
      ctl.min_en  <= reg_wdata[B_MAE];
      ctl.aie     <= reg_wdata[B_AIE];
      ctl.run     <= reg_wdata[B_RUN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (roll && hit)
      flag <= 1'b1;
    else if (wr_ok && reg_addr == A_CTRL && reg_wdata[B_FLAG])
      flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_min  <= '0;
      alm_hour <= '0;
      alm_day  <= '0;
    end else if (wr_ok) begin
      case (reg_addr)
        A_AMIN:  alm_min            <= reg_wdata[MIN_W-1:0];
        A_AHOUR: alm_hour           <= reg_wdata[HOUR_W-1:0];
        A_ADAYL: alm_day[7:0]       <= reg_wdata;
        A_ADAYH: alm_day[DAY_W-1:8] <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {busy, 1'b0, ctl.day_en, ctl.hour_en,
                            ctl.min_en, flag, ctl.aie, ctl.run};
      A_SEC:   reg_rdata = 8'(sec_q);
      A_MIN:   reg_rdata = 8'(min_q);
      A_HOUR:  reg_rdata = 8'(hour_q);
      A_DAYL:  reg_rdata = day_q[7:0];
      A_DAYH:  reg_rdata = 8'(day_q[DAY_W-1:8]);
      A_AMIN:  reg_rdata = 8'(alm_min);
      A_AHOUR: reg_rdata = 8'(alm_hour);
      A_ADAYL: reg_rdata = alm_day[7:0];
      A_ADAYH: reg_rdata = 8'(alm_day[DAY_W-1:8]);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign alarm_irq = flag & ctl.aie;
endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk #(
  parameter int SEC_W  = 7,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic              busy,
  input logic              run_en,
  input logic              flag,
  input logic              alarm_irq,
  input logic [SEC_W-1:0]  sec_q,
  input logic [MIN_W-1:0]  min_q,
  input logic [HOUR_W-1:0] hour_q,
  input logic [DAY_W-1:0]  day_q
);
  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sec_q[3:0] != 4'd9) |=> (sec_q == $past(sec_q) + 1'b1));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sec_q == 'h59) |=> (sec_q == '0));

  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sec_q == 'h59 && min_q == 'h59 && hour_q == 'h23 && (&day_q))
      |=> (day_q == '0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reg_we) |=> $stable({sec_q, min_q, hour_q, day_q}));

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy));

  // R9
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> flag);

  // R10
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == rtcc_pkg::A_CTRL) |=> $stable(run_en));
endmodule

bind rtc_bcd_cal rtcc_chk #(
  .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy), .run_en(run_en), .flag(flag), .alarm_irq(alarm_irq),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_q(day_q)
);

// File: tb/sim_rtc_bcd_cal.sv
`timescale 1ns/1ps
module sim_rtc_bcd_cal;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       alarm_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  rtc_bcd_cal u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .alarm_irq(alarm_irq)
  );

  always #2.5 clk = ~clk;

  localparam logic [1:0] OP_W = 2'd0;
  localparam logic [1:0] OP_R = 2'd1;
  localparam logic [1:0] OP_T = 2'd2;
  localparam int NV = 53;
  // {op, addr, data or expected, requirement number for the message}
  localparam logic [21:0] VECS [0:NV-1] = '{
    {OP_W, 8'h15, 8'h58, 4'd6},  // R6 loads
    {OP_W, 8'h16, 8'h59, 4'd6},
    {OP_W, 8'h17, 8'h23, 4'd6},
    {OP_W, 8'h18, 8'hFF, 4'd6},
    {OP_W, 8'h19, 8'h7F, 4'd6},
    {OP_R, 8'h15, 8'h58, 4'd6},  // R6
    {OP_R, 8'h16, 8'h59, 4'd6},
    {OP_R, 8'h17, 8'h23, 4'd6},
    {OP_R, 8'h18, 8'hFF, 4'd4},  // R4
    {OP_R, 8'h19, 8'h7F, 4'd4},
    {OP_W, 8'h14, 8'h01, 4'd5},  // R5 run on
    {OP_T, 8'h00, 8'h00, 4'd2},
    {OP_R, 8'h15, 8'h59, 4'd2},  // R2
    {OP_T, 8'h00, 8'h00, 4'd2},
    {OP_R, 8'h15, 8'h00, 4'd2},
    {OP_R, 8'h16, 8'h00, 4'd3},  // R3
    {OP_R, 8'h17, 8'h00, 4'd3},
    {OP_R, 8'h18, 8'h00, 4'd4},  // R4 day wrap
    {OP_R, 8'h19, 8'h00, 4'd4},
    {OP_W, 8'h15, 8'h09, 4'd2},
    {OP_T, 8'h00, 8'h00, 4'd2},
    {OP_R, 8'h15, 8'h10, 4'd2},  // R2 digit carry
    {OP_W, 8'h15, 8'h59, 4'd3},
    {OP_W, 8'h16, 8'h09, 4'd3},
    {OP_T, 8'h00, 8'h00, 4'd3},
    {OP_R, 8'h16, 8'h10, 4'd3},  // R3
    {OP_R, 8'h15, 8'h00, 4'd2},
    {OP_W, 8'h15, 8'h59, 4'd3},
    {OP_W, 8'h16, 8'h59, 4'd3},
    {OP_W, 8'h17, 8'h09, 4'd3},
    {OP_T, 8'h00, 8'h00, 4'd3},
    {OP_R, 8'h17, 8'h10, 4'd3},
    {OP_R, 8'h16, 8'h00, 4'd3},
    {OP_W, 8'h18, 8'hFF, 4'd4},
    {OP_W, 8'h19, 8'h00, 4'd4},
    {OP_W, 8'h17, 8'h23, 4'd4},
    {OP_W, 8'h16, 8'h59, 4'd4},
    {OP_W, 8'h15, 8'h59, 4'd4},
    {OP_T, 8'h00, 8'h00, 4'd4},
    {OP_R, 8'h18, 8'h00, 4'd4},  // R4 byte carry
    {OP_R, 8'h19, 8'h01, 4'd4},
    {OP_R, 8'h17, 8'h00, 4'd3},
    {OP_W, 8'h1A, 8'h45, 4'd6},
    {OP_R, 8'h1A, 8'h45, 4'd6},
    {OP_W, 8'h1B, 8'h12, 4'd6},
    {OP_R, 8'h1B, 8'h12, 4'd6},
    {OP_W, 8'h1C, 8'h34, 4'd6},
    {OP_R, 8'h1C, 8'h34, 4'd6},
    {OP_W, 8'h1D, 8'hFF, 4'd6},
    {OP_R, 8'h1D, 8'h7F, 4'd6},
    {OP_R, 8'h20, 8'h00, 4'd6},
    {OP_W, 8'h14, 8'h81, 4'd10}, // R10 bit 7 not writable
    {OP_R, 8'h14, 8'h01, 4'd10}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk);
    #1;
    check(tag, {7'd0, alarm_irq}, {7'd0, exp});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 8'h14; a <= 8'h1D; a++) rd(8'(a), 8'h00, "R1 reset read");
    irq_is(1'b0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] ad, dt;
      logic [3:0] rq;
      {op, ad, dt, rq} = VECS[i];
      case (op)
        OP_W: wr(ad, dt);
        OP_T: tick();
        default: rd(ad, dt, $sformatf("R%0d vector %0d", rq, i));
      endcase
    end

    // R5 stopped counter ignores ticks
    wr(8'h14, 8'h00);
    wr(8'h15, 8'h30);
    tick();
    rd(8'h15, 8'h30, "R5 stopped seconds");

    // R7 flag only where seconds roll to 00
    wr(8'h16, 8'h10); wr(8'h17, 8'h05);
    wr(8'h1A, 8'h10); wr(8'h14, 8'h0B);
    tick();
    rd(8'h14, 8'h0B, "R7 no flag mid-minute");
    irq_is(1'b0, "R7 irq mid-minute");
    wr(8'h1A, 8'h11); wr(8'h15, 8'h59);
    tick();
    rd(8'h16, 8'h11, "R3 minute step");
    rd(8'h14, 8'h0F, "R7 minute match sets flag");
    irq_is(1'b1, "R9 irq with enable");
    // R8 bit 2 = 0 keeps flag; R9 irq gated
    wr(8'h14, 8'h09);
    rd(8'h14, 8'h0D, "R8 flag kept");
    irq_is(1'b0, "R9 irq gated off");
    wr(8'h14, 8'h0F);
    rd(8'h14, 8'h0B, "R8 flag cleared");
    irq_is(1'b0, "R8 irq after clear");

    // R7 no field enabled
    wr(8'h14, 8'h03); wr(8'h16, 8'h10); wr(8'h15, 8'h59);
    tick();
    rd(8'h14, 8'h03, "R7 no field enabled");

    // R7 hour mismatch blocks, then match on both
    wr(8'h1B, 8'h00); wr(8'h16, 8'h10); wr(8'h15, 8'h59); wr(8'h14, 8'h1B);
    tick();
    rd(8'h14, 8'h1B, "R7 hour mismatch");
    wr(8'h1B, 8'h05); wr(8'h16, 8'h10); wr(8'h15, 8'h59);
    tick();
    rd(8'h14, 8'h1F, "R7 minute and hour match");

    // R7 day alarm reached through full carry
    wr(8'h14, 8'h07);
    wr(8'h1C, 8'h05); wr(8'h1D, 8'h00);
    wr(8'h18, 8'h04); wr(8'h19, 8'h00);
    wr(8'h17, 8'h23); wr(8'h16, 8'h59); wr(8'h15, 8'h59);
    wr(8'h14, 8'h23);
    tick();
    rd(8'h18, 8'h05, "R4 day step");
    rd(8'h14, 8'h27, "R7 day match via carry");
    irq_is(1'b1, "R9 irq day alarm");

    // R10 busy bit and writes dropped during a tick
    wr(8'h14, 8'h05);
    wr(8'h15, 8'h20);
    @(negedge clk);
    reg_addr = 8'h14; sec_tick = 1'b1;
    #1;
    check("R10 busy during tick", {7'd0, reg_rdata[7]}, 8'h01);
    @(negedge clk);
    sec_tick = 1'b0;
    rd(8'h14, 8'h01, "R10 busy clear");
    @(negedge clk);
    sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h15; reg_wdata = 8'h40;
    @(negedge clk);
    sec_tick = 1'b0; reg_we = 1'b0;
    rd(8'h15, 8'h22, "R10 write ignored while busy");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule